// File: doc/BRIEF.md
# Sector Erase Collection Queue

This block gathers the set of sectors that a host wants to erase together. A six-write unlock sequence, ending in a sector-erase command aimed at some address, opens a collection window and marks that address's sector. While the window is open, one sector-erase command write to any address inside another sector adds that sector to the pending set. The window is retriggerable. Each write's falling strobe stops the microsecond timer. Each accepted write's rising strobe starts it again from zero. When the configured number of microsecond ticks passes with no write, the block issues a one-cycle launch pulse together with the bitmap of queued sectors.

A command other than sector erase or erase suspend arriving inside the window discards the whole queue and signals a return to read mode. Address and command byte must be valid on the cycle of the rising-strobe input, and both are sampled there. The sector index is the top bits of the address. The low address bits identify the two unlock keys.

Top module: `sector_erase_queue`

## Requirements
- R1: After reset the bitmap is all zero, the window is closed and neither pulse output is high.
- R2: The write sequence 0xAA at key 0x555, 0x55 at key 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, then 0x30 at any address opens the window one cycle after the last rising strobe. Keys compare the low 11 address bits. The bitmap then holds only the bit of that address's sector, which is the index in address bits [13:11].
- R3: A write that breaks the sequence returns the block to read mode, and the window does not open.
- R4: While the window is open, each 0x30 write sets the bit of its sector and keeps all bits already set. Sectors may come in any order, and a repeated sector leaves its bit set.
- R5: The window closes on the WINDOW_US-th microsecond tick after the rising strobe of the last accepted write. The one-cycle launch pulse shows in the next cycle with the queued bitmap, and the bitmap reads zero one cycle later.
- R6: A falling write strobe while the window is open freezes the timer, and ticks during the write are not counted. The matching rising strobe restarts the count from zero.
- R7: An erase-suspend write (0xB0) while the window is open neither changes the queue nor aborts it, and it restarts the timer like any other write.
- R8: Any other command byte written while the window is open gives a one-cycle abort pulse, clears the bitmap and closes the window. No launch follows.
- R9: At launch the bitmap has exactly the sectors that were queued, and every other bit is zero.
- R10: The launch and abort pulses are never high together, and launch never happens with an empty bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_fall | input | 1 | One-cycle strobe, write enable went low |
| wr_rise | input | 1 | One-cycle strobe, write enable went high; address and data sampled |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | CMD_W | Command byte |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| sect_map | output | SECTORS | Queued sector bitmap |
| window_open | output | 1 | Collection window is open |
| erase_go | output | 1 | One-cycle launch pulse |
| abort_read | output | 1 | One-cycle abort, back to read mode |

## Verification
The queue is filled in ascending, descending and repeated orders, and a full eight-sector set is checked. These runs separate a bitmap that keeps bits from one that overwrites them, and show whether the index is taken from the right address bits. The timeout is tested with no retrigger and again with a long write held open across many ticks, which shows whether ticks are counted during a write and whether the rising strobe clears the count. Suspend, a foreign command and a broken unlock sequence each check a separate branch: the queue kept, the queue discarded, and the window never opened.

// File: rtl/sector_erase_queue.sv
module sector_erase_queue #(
  parameter int SECTORS   = 8,
  parameter int KEY_W     = 11,
  parameter int ADDR_W    = KEY_W + $clog2(SECTORS),
  parameter int CMD_W     = 8,
  parameter int WINDOW_US = 80,
  parameter logic [KEY_W-1:0] KEY_A = 11'h555,
  parameter logic [KEY_W-1:0] KEY_B = 11'h2AA,
  parameter logic [CMD_W-1:0] CMD_UNLOCK1 = 8'hAA,
  parameter logic [CMD_W-1:0] CMD_UNLOCK2 = 8'h55,
  parameter logic [CMD_W-1:0] CMD_ARM     = 8'h80,
  parameter logic [CMD_W-1:0] CMD_SECTOR  = 8'h30,
  parameter logic [CMD_W-1:0] CMD_SUSPEND = 8'hB0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_fall,
  input  logic               wr_rise,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CMD_W-1:0]   wr_data,
  input  logic               us_tick,
  output logic [SECTORS-1:0] sect_map,
  output logic               window_open,
  output logic               erase_go,
  output logic               abort_read
);
  localparam int SEC_W = $clog2(SECTORS);
  localparam int CNT_W = $clog2(WINDOW_US + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_US - 1);

  typedef enum logic [2:0] {S_READ, S_K1, S_K2, S_ARM, S_K4, S_K5, S_OPEN} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic              hold;
  logic [SECTORS-1:0] map;
  logic              go, abort;

  wire [SEC_W-1:0]   sec_idx = wr_addr[ADDR_W-1 -: SEC_W];
  wire [SECTORS-1:0] sec_bit = {{(SECTORS-1){1'b0}}, 1'b1} << sec_idx;
  wire key_a   = wr_addr[KEY_W-1:0] == KEY_A;
  wire key_b   = wr_addr[KEY_W-1:0] == KEY_B;
  wire is_ers  = wr_data == CMD_SECTOR;
  wire is_sus  = wr_data == CMD_SUSPEND;
  wire expire  = us_tick && !hold && cnt == LAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_READ;
      cnt   <= '0;
      hold  <= 1'b0;
      map   <= '0;
      go    <= 1'b0;
      abort <= 1'b0;
    end else begin
      go    <= 1'b0;
      abort <= 1'b0;
      if (go) map <= '0;
      case (st)
        S_READ: if (wr_rise && wr_data == CMD_UNLOCK1 && key_a) st <= S_K1;
        S_K1:   if (wr_rise) st <= (wr_data == CMD_UNLOCK2 && key_b) ? S_K2  : S_READ;
        S_K2:   if (wr_rise) st <= (wr_data == CMD_ARM     && key_a) ? S_ARM : S_READ;
        S_ARM:  if (wr_rise) st <= (wr_data == CMD_UNLOCK1 && key_a) ? S_K4  : S_READ;
        S_K4:   if (wr_rise) st <= (wr_data == CMD_UNLOCK2 && key_b) ? S_K5  : S_READ;
        S_K5:
          if (wr_rise) begin
            if (is_ers) begin
              st   <= S_OPEN;
              map  <= sec_bit;
              cnt  <= '0;
              hold <= 1'b0;
            end else begin
              st <= S_READ;
            end
          end
        S_OPEN: begin
          if (wr_fall) hold <= 1'b1;
          if (wr_rise) begin
            hold <= 1'b0;
            cnt  <= '0;
            if (is_ers) begin
              map <= map | sec_bit;
            end else if (!is_sus) begin
              st    <= S_READ;
              map   <= '0;
              abort <= 1'b1;
            end
          end else if (expire) begin
            st <= S_READ;
            go <= 1'b1;
          end else if (us_tick && !hold) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_READ;
      endcase
    end
  end

  assign sect_map    = map;
  assign window_open = st == S_OPEN;
  assign erase_go    = go;
  assign abort_read  = abort;
endmodule

module sector_erase_queue_chk #(
  parameter int SECTORS = 8,
  parameter int CMD_W   = 8,
  parameter logic [CMD_W-1:0] CMD_SUSPEND = 8'hB0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_rise,
  input logic [CMD_W-1:0]   wr_data,
  input logic [SECTORS-1:0] sect_map,
  input logic               window_open,
  input logic               erase_go,
  input logic               abort_read
);
  p_go_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> !erase_go);
  p_map_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> sect_map == '0);
  p_close_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(window_open) |-> (erase_go || abort_read));
  p_keep_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (window_open && $past(window_open)) |-> ((sect_map & $past(sect_map)) == $past(sect_map)));
  p_suspend_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (window_open && wr_rise && wr_data == CMD_SUSPEND) |=> (window_open && !abort_read));
  p_abort_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_read |-> (sect_map == '0 && !window_open));
  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_go && abort_read));
  p_go_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> sect_map != '0);
endmodule

bind sector_erase_queue sector_erase_queue_chk #(
  .SECTORS(SECTORS), .CMD_W(CMD_W), .CMD_SUSPEND(CMD_SUSPEND)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_rise(wr_rise), .wr_data(wr_data),
  .sect_map(sect_map), .window_open(window_open),
  .erase_go(erase_go), .abort_read(abort_read)
);

// File: tb/sector_erase_queue_test.sv
module sector_erase_queue_test;
  localparam int WIN = 80;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, wr_fall = 1'b0, wr_rise = 1'b0, us_tick = 1'b0;
  logic [13:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  sect_map;
  logic window_open, erase_go, abort_read;

  sector_erase_queue uut (
    .clk(clk), .rst_n(rst_n), .wr_fall(wr_fall), .wr_rise(wr_rise),
    .wr_addr(wr_addr), .wr_data(wr_data), .us_tick(us_tick),
    .sect_map(sect_map), .window_open(window_open),
    .erase_go(erase_go), .abort_read(abort_read)
  );

  int errs = 0, checks = 0;
  int go_seen = 0, ab_seen = 0;
  logic [7:0] go_map = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: phase 0..5 = unlock progress, 6 = window open
  int m_ph = 0, m_cnt = 0;
  bit m_hold = 0, m_go = 0, m_ab = 0;
  bit [7:0] m_map = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_hold = 0; m_go = 0; m_ab = 0; m_map = '0;
    end else begin
      bit was_go;
      bit ok;
      bit [7:0] sb;
      was_go = m_go;
      sb = 8'b1 << wr_addr[13:11];
      m_go = 0; m_ab = 0;
      if (was_go) m_map = '0;
      if (m_ph < 6) begin
        if (wr_rise) begin
          case (m_ph)
            0, 3: ok = wr_data == 8'hAA && wr_addr[10:0] == 11'h555;
            1, 4: ok = wr_data == 8'h55 && wr_addr[10:0] == 11'h2AA;
            2:    ok = wr_data == 8'h80 && wr_addr[10:0] == 11'h555;
            default: ok = wr_data == 8'h30;
          endcase
          if (!ok) m_ph = 0;
          else if (m_ph == 5) begin m_ph = 6; m_map = sb; m_cnt = 0; m_hold = 0; end
          else m_ph++;
        end
      end else begin
        if (wr_rise) begin
          m_cnt = 0;
          if (wr_data == 8'h30) m_map |= sb;
          else if (wr_data != 8'hB0) begin m_ph = 0; m_map = '0; m_ab = 1; end
        end else if (us_tick && !m_hold) begin
          m_cnt++;
          if (m_cnt == WIN) begin m_go = 1; m_ph = 0; end
        end
        if (wr_rise) m_hold = 0;
        else if (wr_fall) m_hold = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(sect_map == m_map, "R4", "bitmap vs model", sect_map, m_map);
      chk(erase_go == m_go, "R5", "launch vs model", erase_go, m_go);
      chk(abort_read == m_ab, "R8", "abort vs model", abort_read, m_ab);
      chk(window_open == (m_ph == 6), "R2", "window vs model", window_open, m_ph == 6);
      chk(!(erase_go && abort_read), "R10", "launch with abort", 1, 0);
      if (erase_go) begin go_seen++; go_map = sect_map; end
      if (abort_read) ab_seen++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [13:0] a, input logic [7:0] d);
    @(negedge clk); wr_addr = a; wr_data = d; wr_fall = 1'b1;
    @(negedge clk); wr_fall = 1'b0;
    @(negedge clk); wr_rise = 1'b1;
    @(negedge clk); wr_rise = 1'b0;
    idle(1);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); us_tick = 1'b1;
      @(negedge clk); us_tick = 1'b0;
      idle(2);
    end
  endtask

  task automatic open_seq(input int sec);
    wr(14'h0555, 8'hAA); wr(14'h02AA, 8'h55); wr(14'h0555, 8'h80);
    wr(14'h0555, 8'hAA); wr(14'h02AA, 8'h55);
    wr({sec[2:0], 11'h123}, 8'h30);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R5 watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    int g;
    idle(3);
    #1;
    chk(sect_map == 0 && !window_open && !erase_go && !abort_read, "R1", "reset state",
        {sect_map, window_open, erase_go, abort_read}, 0);
    rst_n = 1'b1;

    // R2/R4/R5/R9: ascending and repeated adds, plain expiry
    open_seq(5); #1;
    chk(window_open && sect_map == 8'h20, "R2", "window after sequence", sect_map, 8'h20);
    wr({3'd2, 11'h7FF}, 8'h30); wr({3'd5, 11'h000}, 8'h30); wr({3'd7, 11'h040}, 8'h30); #1;
    chk(sect_map == 8'hA4, "R4", "bitmap after adds", sect_map, 8'hA4);
    g = go_seen;
    ticks(WIN - 1); #1;
    chk(go_seen == g && window_open, "R5", "no launch before window ends", go_seen - g, 0);
    ticks(1); #1;
    chk(go_seen == g + 1, "R5", "launch count", go_seen - g, 1);
    chk(go_map == 8'hA4, "R9", "launched bitmap", go_map, 8'hA4);
    chk(sect_map == 0 && !window_open, "R5", "bitmap cleared after launch", sect_map, 0);

    // R3: broken sequence
    wr(14'h0555, 8'hAA); wr(14'h02AA, 8'h55); wr(14'h0555, 8'h90);
    wr(14'h0555, 8'hAA); wr(14'h02AA, 8'h55); wr(14'h0555, 8'h30); #1;
    chk(!window_open && sect_map == 0, "R3", "window stays closed", window_open, 0);

    // R6: long write holds timer, rise restarts it
    open_seq(1);
    ticks(60);
    g = go_seen;
    @(negedge clk); wr_addr = {3'd3, 11'h010}; wr_data = 8'h30; wr_fall = 1'b1;
    @(negedge clk); wr_fall = 1'b0;
    ticks(30); #1;
    chk(go_seen == g && window_open, "R6", "timer frozen during write", go_seen - g, 0);
    @(negedge clk); wr_rise = 1'b1;
    @(negedge clk); wr_rise = 1'b0;
    ticks(WIN - 1); #1;
    chk(go_seen == g, "R6", "count restarted at rise", go_seen - g, 0);
    ticks(1); #1;
    chk(go_seen == g + 1 && go_map == 8'h0A, "R6", "launch map after retrigger", go_map, 8'h0A);

    // R7: suspend keeps queue, restarts timer
    open_seq(4);
    ticks(50);
    g = ab_seen;
    wr(14'h1234, 8'hB0); #1;
    chk(window_open && sect_map == 8'h10 && ab_seen == g, "R7", "queue kept on suspend",
        sect_map, 8'h10);
    g = go_seen;
    ticks(WIN - 1); #1;
    chk(go_seen == g, "R7", "suspend restarted timer", go_seen - g, 0);
    ticks(1); #1;
    chk(go_seen == g + 1, "R7", "launch after suspend", go_seen - g, 1);

    // R8: foreign command aborts
    open_seq(6);
    wr({3'd0, 11'h001}, 8'h30);
    g = ab_seen;
    wr(14'h0555, 8'hF0); #1;
    chk(ab_seen == g + 1, "R8", "abort pulse", ab_seen - g, 1);
    chk(sect_map == 0 && !window_open, "R8", "queue cleared", sect_map, 0);
    g = go_seen;
    ticks(WIN + 20); #1;
    chk(go_seen == g, "R8", "no launch after abort", go_seen - g, 0);

    // R4/R9: descending fill of every sector
    open_seq(7);
    for (int s = 6; s >= 0; s--) wr({s[2:0], 11'h2AA}, 8'h30);
    wr({3'd7, 11'h555}, 8'h30); #1;
    chk(sect_map == 8'hFF, "R4", "full bitmap", sect_map, 8'hFF);
    g = go_seen;
    ticks(WIN); #1;
    chk(go_seen == g + 1 && go_map == 8'hFF, "R9", "full launch map", go_map, 8'hFF);

    idle(4);
    summary();
  end
endmodule